// File: doc/BRIEF.md
# Phit-to-flit link serializer and deserializer

This block is both ends of a narrow link that carries wide flits. On the sending side, a flit of 64 data bits and 6 control bits is cut into five 14-bit phits. The phits go out one per link clock, starting with the most significant. On the receiving side, five phits are gathered back into one flit. The flit is presented on registered data and control outputs. The receiver then follows the packet framing carried in the control bits: a head flit opens a request packet of either one flit or eight flits. The receiver marks the final flit of each packet and flags packets whose actual length differs from the length the head announced.

The whole block runs on the link clock. In that clock, a core cycle is five link cycles, so at most one flit is sent and at most one flit is received per core cycle. Moving the received flit into the switch clock domain happens downstream and is not part of this block. The sender always inserts the start marker (the top control bit, which is the top bit of the first phit). The receiver uses that bit to find flit boundaries. While the receiver is between flits, any phit whose top bit is clear is discarded. As a result, a receiver that has slipped out of step finishes the damaged flit it is holding and then locks back on at the next marked phit.

Top module: `phit_link`

## Requirements
- R1: After reset, `tx_ready_o` is high for exactly one cycle in every five, first in the fifth cycle after reset. The send inputs are sampled at the rising edge that ends a cycle in which `tx_ready_o` is high.
- R2: A flit is formed as `{1'b1, tx_ctrl_i, tx_data_i}` (70 bits, bit 69 being the start marker). It leaves on `tx_phit_o` in the five cycles that follow the sampling edge. Phit k carries flit bits [69-14k : 56-14k].
- R3: If `tx_valid_i` is low at a sampling edge, the next five phits are all zero.
- R4: When the receiver is between flits, a phit with bit 13 set starts a new flit. A phit with bit 13 clear is discarded and produces no output flit.
- R5: In the cycle after the fifth phit of a flit, `rx_valid_o` is high for one cycle. At that point `rx_data_o` holds flit bits [63:0] and `rx_ctrl_o` holds bits [69:64]. Both keep those values until the next flit is received.
- R6: When `tx_phit_o` is looped back into `rx_phit_i`, every sent flit appears unchanged, with `rx_valid_o` high six cycles after its sampling edge. This holds for flits sent back to back.
- R7: If the sender is stopped after the first 1 to 4 phits of a flit, the receiver completes that flit with the phits that follow. After that it realigns on the next marked phit, and the flits that come after are received intact.
- R8: Control bit 4 (flit bit 68) marks a head flit. Control bit 3 (flit bit 67) gives the packet length: 0 for one flit, 1 for eight flits. `rx_last_o` is high with the final flit of a packet of correct length.
- R9: A head flit that arrives while a packet is still open raises `rx_short_err_o` with that head flit. The head flit then opens its own packet.
- R10: A non-head flit that arrives when no packet is open raises `rx_stray_err_o`, and `rx_last_o` stays low for it.
- R11: While `rst_n` is low at a clock edge, the block resets: `tx_phit_o`, `rx_valid_o`, `rx_data_o`, `rx_ctrl_o` and `tx_ready_o` are all zero, and no packet is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock, five per core cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_valid_i | input | 1 | A flit is offered at this sampling slot |
| tx_data_i | input | 64 | Data word of the offered flit |
| tx_ctrl_i | input | 5 | Control bits 4:0: head, long, write, two user bits |
| tx_ready_o | output | 1 | Sampling slot: inputs are taken at the next edge |
| tx_phit_o | output | 14 | Outgoing phit |
| rx_phit_i | input | 14 | Incoming phit |
| rx_valid_o | output | 1 | One-cycle strobe for a received flit |
| rx_data_o | output | 64 | Received data word, held between flits |
| rx_ctrl_o | output | 6 | Received control bits including the marker, held |
| rx_last_o | output | 1 | Final flit of a packet of correct length |
| rx_short_err_o | output | 1 | A new head flit arrived before the open packet was complete |
| rx_stray_err_o | output | 1 | A body flit arrived with no packet open |

## Verification
The bench builds the block with its default values: 14-bit phits, five phits per flit, and long packets of eight flits. These are small enough that every flit phase can be covered. It sends 64 single-flit packets with a walking data bit, full eight-flit packets, and every truncation of a long packet from zero to six body flits. It also sends body flits beyond the end of a packet, and idle slots. With the link driven directly, it cuts a flit after each possible phit count from one to four. Unmarked junk phits follow each cut, and the bench checks that the receiver relocks on the next marker.

// File: rtl/phit_link_pkg.sv
// Shared constants for the phit link: where the framing fields sit within
// the control bits, counted downward from the control MSB (the start marker).
package phit_link_pkg;
    localparam int unsigned HEAD_OFS  = 1;  // head-of-packet flag
    localparam int unsigned LONG_OFS  = 2;  // 0: one-flit packet, 1: long packet
    localparam int unsigned WRITE_OFS = 3;  // write (1) or read (0) request

    // Verdict of the packet length tracker for one received flit.
    typedef struct packed {
        logic last;
        logic short_err;
        logic stray_err;
    } len_verdict_t;
endpackage

// File: rtl/phit_tx_ser.sv
// Sender: every PHITS cycles it samples one flit (or idle). Then it shifts
// the flit out PHIT_W bits at a time, MSB first. The start marker is
// forced on for valid flits. Assumes PHIT_W*PHITS == DATA_W+CTRL_W.
module phit_tx_ser #(
    parameter int unsigned PHIT_W = 14,
    parameter int unsigned PHITS  = 5,
    parameter int unsigned DATA_W = 64,
    parameter int unsigned CTRL_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [CTRL_W-2:0] ctrl_i,
    output logic              ready_o,
    output logic [PHIT_W-1:0] phit_o
);
    localparam int unsigned FLIT_W = PHIT_W * PHITS;
    localparam int unsigned CNT_W  = $clog2(PHITS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PHITS - 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [FLIT_W-1:0] shift_q;

    // Phase counter: marks which phit of the current flit is on the wire.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    // Shift register: load a flit (or zeros) on the last phase, else shift.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shift_q <= '0;
        else if (cnt_q == LAST)
            shift_q <= valid_i ? FLIT_W'({1'b1, ctrl_i, data_i}) : '0;
        else
            shift_q <= shift_q << PHIT_W;
    end

    assign ready_o = (cnt_q == LAST);
    assign phit_o  = shift_q[FLIT_W-1 -: PHIT_W];
endmodule

// File: rtl/phit_rx_deser.sv
// Receiver: gathers PHITS phits into one flit. Between flits it waits for a
// phit whose MSB (the start marker) is set and drops the others. The
// assembled flit is registered, with a one-cycle valid strobe.
// Assumes PHITS >= 3.
module phit_rx_deser #(
    parameter int unsigned PHIT_W = 14,
    parameter int unsigned PHITS  = 5,
    parameter int unsigned DATA_W = 64,
    parameter int unsigned CTRL_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PHIT_W-1:0] phit_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o,
    output logic [CTRL_W-1:0] ctrl_o
);
    localparam int unsigned ACC_W = PHIT_W * (PHITS - 1);
    localparam int unsigned CNT_W = $clog2(PHITS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PHITS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [ACC_W-1:0] acc_q;
    logic             start;
    logic             take;

    assign start = phit_i[PHIT_W-1];
    assign take  = (cnt_q == '0) ? start : (cnt_q != LAST);

    // Phase counter: holds at zero until a marked phit arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (cnt_q == '0)   cnt_q <= start ? CNT_W'(1) : '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    // Accumulator: collects the leading phits of the flit in order.
    always_ff @(posedge clk) begin
        if (!rst_n)    acc_q <= '0;
        else if (take) acc_q <= {acc_q[ACC_W-PHIT_W-1:0], phit_i};
    end

    // Output register: captures the full flit on its final phit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            data_o  <= '0;
            ctrl_o  <= '0;
        end else begin
            valid_o <= (cnt_q == LAST);
            if (cnt_q == LAST)
                {ctrl_o, data_o} <= (DATA_W + CTRL_W)'({acc_q, phit_i});
        end
    end
endmodule

// File: rtl/pkt_len_check.sv
// Packet length tracker: follows head flits and their announced length
// (one flit or LONG_LEN flits). It marks the closing flit and flags
// truncated packets and stray body flits. Flags are combinational on the
// registered flit and line up with its valid strobe.
module pkt_len_check #(
    parameter int unsigned LONG_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flit_valid_i,
    input  logic head_i,
    input  logic long_i,
    output logic last_o,
    output logic short_err_o,
    output logic stray_err_o
);
    import phit_link_pkg::*;

    localparam int unsigned RW = $clog2(LONG_LEN);

    logic [RW-1:0] rem_q, rem_d;
    len_verdict_t  verdict;

    // Next-state and verdict for the flit on the inputs.
    always_comb begin
        rem_d   = rem_q;
        verdict = '0;
        if (flit_valid_i) begin
            if (head_i) begin
                verdict.short_err = (rem_q != '0);
                if (long_i) begin
                    rem_d = RW'(LONG_LEN - 1);
                end else begin
                    rem_d        = '0;
                    verdict.last = 1'b1;
                end
            end else if (rem_q != '0) begin
                rem_d        = rem_q - 1'b1;
                verdict.last = (rem_q == RW'(1));
            end else begin
                verdict.stray_err = 1'b1;
            end
        end
    end

    // Remaining-flit counter of the open packet; zero means none open.
    always_ff @(posedge clk) begin
        if (!rst_n) rem_q <= '0;
        else        rem_q <= rem_d;
    end

    assign last_o      = verdict.last;
    assign short_err_o = verdict.short_err;
    assign stray_err_o = verdict.stray_err;
endmodule

// File: rtl/phit_link.sv
// Top of the phit link: sender, receiver and packet length tracker, all on
// the link clock. The sender and receiver share no state, so the two phit
// ports may be looped back or wired to a far end.
module phit_link #(
    parameter int unsigned PHIT_W   = 14,
    parameter int unsigned PHITS    = 5,
    parameter int unsigned DATA_W   = 64,
    parameter int unsigned CTRL_W   = 6,
    parameter int unsigned LONG_LEN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_valid_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic [CTRL_W-2:0] tx_ctrl_i,
    output logic              tx_ready_o,
    output logic [PHIT_W-1:0] tx_phit_o,
    input  logic [PHIT_W-1:0] rx_phit_i,
    output logic              rx_valid_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic [CTRL_W-1:0] rx_ctrl_o,
    output logic              rx_last_o,
    output logic              rx_short_err_o,
    output logic              rx_stray_err_o
);
    import phit_link_pkg::*;

    phit_tx_ser #(.PHIT_W(PHIT_W), .PHITS(PHITS), .DATA_W(DATA_W), .CTRL_W(CTRL_W)) tx_i (
        .clk(clk), .rst_n(rst_n), .valid_i(tx_valid_i), .data_i(tx_data_i),
        .ctrl_i(tx_ctrl_i), .ready_o(tx_ready_o), .phit_o(tx_phit_o)
    );

    phit_rx_deser #(.PHIT_W(PHIT_W), .PHITS(PHITS), .DATA_W(DATA_W), .CTRL_W(CTRL_W)) rx_i (
        .clk(clk), .rst_n(rst_n), .phit_i(rx_phit_i), .valid_o(rx_valid_o),
        .data_o(rx_data_o), .ctrl_o(rx_ctrl_o)
    );

    pkt_len_check #(.LONG_LEN(LONG_LEN)) len_i (
        .clk(clk), .rst_n(rst_n), .flit_valid_i(rx_valid_o),
        .head_i(rx_ctrl_o[CTRL_W-1-HEAD_OFS]), .long_i(rx_ctrl_o[CTRL_W-1-LONG_OFS]),
        .last_o(rx_last_o), .short_err_o(rx_short_err_o), .stray_err_o(rx_stray_err_o)
    );
endmodule

// File: rtl/phit_link_chk.sv
// Property checker for phit_link: cadence of the sender, spacing and
// holding of received flits, and consistency of the packet flags.
module phit_link_chk #(
    parameter int unsigned PHIT_W = 14,
    parameter int unsigned PHITS  = 5,
    parameter int unsigned DATA_W = 64,
    parameter int unsigned CTRL_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_valid_i,
    input logic              tx_ready_o,
    input logic [PHIT_W-1:0] tx_phit_o,
    input logic              rx_valid_o,
    input logic [DATA_W-1:0] rx_data_o,
    input logic [CTRL_W-1:0] rx_ctrl_o,
    input logic              rx_last_o,
    input logic              rx_short_err_o,
    input logic              rx_stray_err_o
);
    localparam int unsigned GW = $clog2(PHITS + 1);

    logic [GW-1:0] tx_gap_q;
    logic [GW-1:0] rx_gap_q;

    // Cycles since the last sampling slot, saturating at PHITS.
    always_ff @(posedge clk) begin
        if (!rst_n)              tx_gap_q <= GW'(1);
        else if (tx_ready_o)     tx_gap_q <= GW'(1);
        else if (tx_gap_q < GW'(PHITS)) tx_gap_q <= tx_gap_q + 1'b1;
    end

    // Cycles since the last received flit, saturating at PHITS.
    always_ff @(posedge clk) begin
        if (!rst_n)              rx_gap_q <= GW'(PHITS);
        else if (rx_valid_o)     rx_gap_q <= GW'(1);
        else if (rx_gap_q < GW'(PHITS)) rx_gap_q <= rx_gap_q + 1'b1;
    end

    assert_tx_cadence_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready_o == (tx_gap_q == GW'(PHITS)));

    assert_idle_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready_o && !tx_valid_i) |=> (tx_phit_o == '0));

    assert_marker_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> rx_ctrl_o[CTRL_W-1]);

    assert_flit_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> (rx_gap_q >= GW'(PHITS)));

    assert_held_between_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid_o |-> ($stable(rx_data_o) && $stable(rx_ctrl_o)));

    assert_flags_need_flit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_last_o || rx_short_err_o || rx_stray_err_o) |-> rx_valid_o);

    assert_short_on_head_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_short_err_o |-> rx_ctrl_o[CTRL_W-2]);

    assert_stray_on_body_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stray_err_o |-> (!rx_ctrl_o[CTRL_W-2] && !rx_last_o));
endmodule

bind phit_link phit_link_chk #(.PHIT_W(PHIT_W), .PHITS(PHITS), .DATA_W(DATA_W), .CTRL_W(CTRL_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o),
    .tx_phit_o(tx_phit_o), .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o),
    .rx_ctrl_o(rx_ctrl_o), .rx_last_o(rx_last_o), .rx_short_err_o(rx_short_err_o),
    .rx_stray_err_o(rx_stray_err_o)
);

// File: tb/phit_link_tb_top.sv
// Bench for phit_link: loopback sweeps over packet shapes, plus direct
// phit injection for cut flits and relocking.
module phit_link_tb_top;
    localparam int PHIT_W = 14, PHITS = 5, DATA_W = 64, CTRL_W = 6, LONG_LEN = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              tx_valid = 1'b0;
    logic [63:0]       tx_data = '0;
    logic [4:0]        tx_ctrl = '0;
    logic              tx_ready;
    logic [13:0]       tx_phit, rx_phit;
    logic              rx_valid, rx_last, rx_short, rx_stray;
    logic [63:0]       rx_data;
    logic [5:0]        rx_ctrl;
    logic              inj = 1'b0;
    logic [13:0]       inj_phit = '0;

    assign rx_phit = inj ? inj_phit : tx_phit;

    phit_link #(.PHIT_W(PHIT_W), .PHITS(PHITS), .DATA_W(DATA_W), .CTRL_W(CTRL_W),
                .LONG_LEN(LONG_LEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .tx_valid_i(tx_valid), .tx_data_i(tx_data),
        .tx_ctrl_i(tx_ctrl), .tx_ready_o(tx_ready), .tx_phit_o(tx_phit),
        .rx_phit_i(rx_phit), .rx_valid_o(rx_valid), .rx_data_o(rx_data),
        .rx_ctrl_o(rx_ctrl), .rx_last_o(rx_last), .rx_short_err_o(rx_short),
        .rx_stray_err_o(rx_stray)
    );

    int n_cmp = 0, n_bad = 0, cyc = 0, m_rem = 0;
    logic [69:0] q_flit[$];
    logic [2:0]  q_flag[$];
    int          q_time[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input logic [69:0] act, input logic [69:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Packet model: flags {last, short, stray} for the flit in arrival order (R8 R9 R10).
    task automatic expect_flit(input logic [69:0] f, input int t);
        logic last = 0, shrt = 0, stray = 0;
        if (f[68]) begin
            shrt = (m_rem != 0);
            if (f[67]) m_rem = LONG_LEN - 1;
            else begin m_rem = 0; last = 1; end
        end else if (m_rem != 0) begin
            m_rem--;
            last = (m_rem == 0);
        end else stray = 1;
        q_flit.push_back(f);
        q_flag.push_back({last, shrt, stray});
        q_time.push_back(t);
    endtask

    // Received-flit monitor: compares content, flags and loopback latency.
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (q_flit.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R4 unexpected flit actual=%h expected=none", {rx_ctrl, rx_data});
            end else begin
                logic [69:0] f;
                logic [2:0]  fl;
                int          t;
                f = q_flit.pop_front(); fl = q_flag.pop_front(); t = q_time.pop_front();
                chk("R5 flit content", {rx_ctrl, rx_data}, f);
                chk("R8 R9 R10 last/short/stray", 70'({rx_last, rx_short, rx_stray}), 70'(fl));
                if (t >= 0) chk("R6 loopback latency", 70'(cyc - t), 70'd6);
            end
        end
    end

    task automatic send(input logic [4:0] c, input logic [63:0] d);
        do @(negedge clk); while (!tx_ready);
        tx_valid = 1'b1; tx_ctrl = c; tx_data = d;
        expect_flit({1'b1, c, d}, cyc);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    // Called at the negedge showing phit 0: checks the five phits (R2).
    task automatic watch_phits(input logic [69:0] f);
        for (int k = 0; k < PHITS; k++) begin
            if (k > 0) @(negedge clk);
            chk("R2 phit order", 70'(tx_phit), 70'(f[69-14*k -: 14]));
        end
    endtask

    task automatic idle_slot();
        do @(negedge clk); while (!tx_ready);
        tx_valid = 1'b0;
        for (int k = 0; k < PHITS; k++) begin
            @(negedge clk);
            chk("R3 idle phit zero", 70'(tx_phit), 70'd0);
        end
    endtask

    task automatic drain();
        while (q_flit.size() != 0) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    // Cut a flit after k phits, then zeros, junk, and a good flit (R7, R4).
    task automatic cut_and_relock(input int k);
        logic [69:0] pf, gf, bogus;
        pf = {14'h3000 + 14'(k), 14'h0123, 14'h0456, 14'h0789, 14'h0ABC};
        gf = {14'h3055, 14'h2AAA, 14'h1555, 14'h3C3C, 14'h03C3};
        bogus = pf & ({70{1'b1}} << (14 * (PHITS - k)));
        expect_flit(bogus, -1);
        expect_flit(gf, -1);
        @(negedge clk);
        inj = 1'b1;
        for (int i = 0; i < PHITS; i++) begin
            inj_phit = (i < k) ? pf[69-14*i -: 14] : 14'h0;
            @(negedge clk);
        end
        for (int i = 0; i < 3; i++) begin
            inj_phit = 14'h0ABC;
            @(negedge clk);
        end
        for (int i = 0; i < PHITS; i++) begin
            inj_phit = gf[69-14*i -: 14];
            @(negedge clk);
        end
        inj_phit = '0;
        repeat (3) @(negedge clk);
        inj = 1'b0;
        drain();
    endtask

    bit done = 0;

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: state under reset
        chk("R11 reset phit", 70'(tx_phit), 70'd0);
        chk("R11 reset valid/ready", 70'({rx_valid, tx_ready}), 70'd0);
        chk("R11 reset rx outputs", {rx_ctrl, rx_data}, 70'd0);
        rst_n = 1'b1;
        idle_slot();
        // Single-flit packets with walking data bit (R2, R5, R6, R8)
        for (int i = 0; i < 64; i++) begin
            logic [4:0] c;
            c = {2'b10, 1'(i), 2'(i >> 1)};
            send(c, (64'h1 << i) ^ {32'(i), 32'hC0DE0000});
            if (i < 4) watch_phits({1'b1, c, (64'h1 << i) ^ {32'(i), 32'hC0DE0000}});
        end
        // Long packets of eight flits, back to back (R8, R6)
        for (int p = 0; p < 4; p++) begin
            send({2'b11, 1'(p), 2'b01}, 64'hA5A5_0000_0000_0000 + 64'(p));
            for (int j = 1; j < LONG_LEN; j++)
                send({2'b00, 1'(p), 2'b10}, 64'(p * 1000 + j * 17));
        end
        // Truncated long packets, each followed by a one-flit head (R9)
        for (int k = 0; k < LONG_LEN - 1; k++) begin
            send(5'b11000, 64'hDEAD_0000 + 64'(k));
            for (int j = 0; j < k; j++) send(5'b00000, 64'(j));
            send(5'b10100, 64'hBEEF_0000 + 64'(k));
        end
        // Stray body flits, and one past the end of a long packet (R10)
        for (int j = 0; j < 3; j++) send(5'b00011, 64'hFFFF_FFFF_FFFF_FFF0 + 64'(j));
        send(5'b11100, 64'h1);
        for (int j = 1; j < LONG_LEN; j++) send(5'b00100, 64'(j));
        send(5'b00100, 64'h99);
        idle_slot();
        drain();
        // Cut flits at every possible point and relock (R7, R4)
        for (int k = 1; k < PHITS; k++) cut_and_relock(k);
        // Loopback still works afterwards (R6)
        send(5'b10000, 64'h0123_4567_89AB_CDEF);
        drain();
        chk("R6 all flits delivered", 70'(q_flit.size()), 70'd0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule